// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Macrocell

This block is one output cell of a small programmable-array logic device. Each array input is offered to the AND plane in both its true and its inverted form. A connect fuse for every literal of every product term chooses which literals that term uses. The product terms are ORed into one sum. A polarity fuse then inverts the sum or passes it unchanged.

A mode bit then picks the path to the pin. One path is combinational. The other is a D flip-flop that samples the polarity-adjusted sum on every rising clock edge. The fuse map, polarity and mode are static configuration vectors, held steady by the surrounding logic during normal use. Widths follow parameters, and the defaults give 16 array inputs and 8 product terms.

Top module: `pal_macrocell`

## Requirements
- R1: Literal 2k of a term is array input k and literal 2k+1 is its complement. The connect fuse for literal l of term t sits at fuse_i bit t*2*N_IN + l, and 1 means connected. A term is the AND of its connected literals, so a term that connects both literals of one input is always 0.
- R2: An unconnected literal has no effect on its term. A term that connects a single literal equals that literal.
- R3: A term with no connected literals is 0 and adds nothing to the sum.
- R4: The sum is the OR of all N_TERMS product terms, including the highest-numbered term.
- R5: With pol_i = 1 the output is the inverted sum. With pol_i = 0 it is the sum unchanged.
- R6: With reg_mode_i = 0, out_o equals the polarity-adjusted sum within the same cycle, with no clock edge needed.
- R7: With reg_mode_i = 1, out_o takes the polarity-adjusted sum present at each rising clock edge and holds that value while inputs change between edges.
- R8: While rst_ni is low the flip-flop is cleared at once, without waiting for a clock edge. In registered mode out_o is then 0, and it stays 0 across clock edges until reset is released.
- R9: The flip-flop samples on every edge in either mode. When reg_mode_i switches from 0 to 1, out_o shows the value sampled at the most recent edge, not the current combinational value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output flip-flop |
| rst_ni | input | 1 | Active-low asynchronous reset of the flip-flop |
| arr_i | input | N_IN | Array input signals |
| fuse_i | input | N_TERMS*2*N_IN | Connect fuse per literal per term, 1 = connected |
| pol_i | input | 1 | Polarity fuse, 1 = invert the sum |
| reg_mode_i | input | 1 | 1 = registered output, 0 = combinational output |
| out_o | output | 1 | Macrocell result |

## Verification
A mode switch and an array-input change can fall between the same two clock edges. They interact because the flip-flop keeps sampling in combinational mode. The bench provokes this by letting one value be sampled in combinational mode, then changing the array inputs and setting registered mode together before the next edge. It judges the result by requiring the previously sampled value on the pin until that edge, and the new sum one edge later. A second overlap is an asynchronous reset arriving while a 1 is held, which must clear the output before any edge.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned LIT_PER_IN = 2;

  typedef enum logic {
    MODE_COMB = 1'b0,
    MODE_REG  = 1'b1
  } out_mode_e;
endpackage

// File: rtl/pal_literals.sv
module pal_literals #(
  parameter int unsigned N_IN = 16,
  localparam int unsigned LITS = N_IN * pal_pkg::LIT_PER_IN
) (
  input  logic [N_IN-1:0] arr_i,
  output logic [LITS-1:0] lit_o
);
  for (genvar k = 0; k < N_IN; k++) begin : g_lit
    assign lit_o[2*k]   = arr_i[k];
    assign lit_o[2*k+1] = ~arr_i[k];
  end
endmodule

// File: rtl/pal_pterm.sv
module pal_pterm #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] lit_i,
  input  logic [W-1:0] fuse_i,
  output logic         term_o
);
  logic any_conn;
  logic all_true;

  // open literals read as 1; an empty term is forced low
  assign any_conn = |fuse_i;
  assign all_true = &(lit_i | ~fuse_i);
  assign term_o   = any_conn & all_true;
endmodule

// File: rtl/pal_sum_pol.sv
module pal_sum_pol #(
  parameter int unsigned N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] term_i,
  input  logic               pol_i,
  output logic               sum_o,
  output logic               pol_o
);
  assign sum_o = |term_i;
  assign pol_o = sum_o ^ pol_i;
endmodule

// File: rtl/pal_out_stage.sv
module pal_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic reg_mode_i,
  output logic q_o
);
  import pal_pkg::*;

  logic      q_r;
  out_mode_e mode;

  // flop samples every edge regardless of mode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= 1'b0;
    else         q_r <= d_i;
  end

  assign mode = out_mode_e'(reg_mode_i);
  assign q_o  = (mode == MODE_REG) ? q_r : d_i;
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int unsigned N_IN    = 16,
  parameter int unsigned N_TERMS = 8,
  localparam int unsigned LITS   = N_IN * pal_pkg::LIT_PER_IN,
  localparam int unsigned FUSES  = N_TERMS * LITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IN-1:0]  arr_i,
  input  logic [FUSES-1:0] fuse_i,
  input  logic             pol_i,
  input  logic             reg_mode_i,
  output logic             out_o
);
  logic [LITS-1:0]    lit_w;
  logic [N_TERMS-1:0] term_w;
  logic               sum_w;
  logic               xor_w;

  pal_literals #(.N_IN(N_IN)) u_lit (
    .arr_i (arr_i),
    .lit_o (lit_w)
  );

  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    pal_pterm #(.W(LITS)) u_pt (
      .lit_i  (lit_w),
      .fuse_i (fuse_i[t*LITS +: LITS]),
      .term_o (term_w[t])
    );
  end

  pal_sum_pol #(.N_TERMS(N_TERMS)) u_sum (
    .term_i (term_w),
    .pol_i  (pol_i),
    .sum_o  (sum_w),
    .pol_o  (xor_w)
  );

  pal_out_stage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .d_i        (xor_w),
    .reg_mode_i (reg_mode_i),
    .q_o        (out_o)
  );
endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
  parameter int unsigned N_IN    = 16,
  parameter int unsigned N_TERMS = 8,
  localparam int unsigned LITS   = N_IN * pal_pkg::LIT_PER_IN,
  localparam int unsigned FUSES  = N_TERMS * LITS
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [FUSES-1:0] fuse_i,
  input logic             pol_i,
  input logic             reg_mode_i,
  input logic             out_o,
  input logic [N_TERMS-1:0] term_w,
  input logic             sum_w,
  input logic             xor_w
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : g_chk
    p_empty_term_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fuse_i[t*LITS +: LITS] == '0) |-> !term_w[t]);
  end

  p_invert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i && !reg_mode_i) |-> (out_o != sum_w));

  p_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pol_i && !reg_mode_i) |-> (out_o == sum_w));

  p_comb_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_mode_i |-> (out_o == xor_w));

  p_reg_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && reg_mode_i) |-> (out_o == $past(xor_w)));
endmodule

bind pal_macrocell pal_macrocell_chk #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fuse_i     (fuse_i),
  .pol_i      (pol_i),
  .reg_mode_i (reg_mode_i),
  .out_o      (out_o),
  .term_w     (term_w),
  .sum_w      (sum_w),
  .xor_w      (xor_w)
);

// File: tb/sim_pal_macrocell.sv
`timescale 1ns/1ps
module sim_pal_macrocell;
  localparam int N_IN    = 16;
  localparam int N_TERMS = 8;
  localparam int LITS    = 2 * N_IN;
  localparam int FUSES   = N_TERMS * LITS;

  typedef struct packed {
    logic [15:0] arr;
    logic        pol;
    logic        mode;
    logic [31:0] seed;
  } vec_t;

  localparam vec_t VT [0:11] = '{
    '{16'hA5C3, 1'b0, 1'b0, 32'h0000_0001},
    '{16'h5A3C, 1'b1, 1'b0, 32'h1234_5678},
    '{16'hFFFF, 1'b0, 1'b1, 32'h0BAD_F00D},
    '{16'h0000, 1'b1, 1'b1, 32'hDEAD_BEEF},
    '{16'h0F0F, 1'b0, 1'b0, 32'h0000_3C3C},
    '{16'hF0F0, 1'b1, 1'b1, 32'h7777_1111},
    '{16'h8001, 1'b0, 1'b1, 32'h0102_0304},
    '{16'h7FFE, 1'b1, 1'b0, 32'hCAFE_0001},
    '{16'h3333, 1'b0, 1'b0, 32'h9999_0000},
    '{16'hCCCC, 1'b1, 1'b1, 32'h4242_4242},
    '{16'h1248, 1'b0, 1'b1, 32'h0F1E_2D3C},
    '{16'hEDB7, 1'b1, 1'b0, 32'h5555_AAAA}
  };

  logic             clk = 1'b0;
  logic             rst_ni;
  logic [N_IN-1:0]  arr;
  logic [FUSES-1:0] fuse;
  logic             pol;
  logic             mode;
  logic             out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pal_macrocell #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .arr_i      (arr),
    .fuse_i     (fuse),
    .pol_i      (pol),
    .reg_mode_i (mode),
    .out_o      (out)
  );

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] r = s;
    r = r ^ (r << 13);
    r = r ^ (r >> 17);
    r = r ^ (r << 5);
    return r;
  endfunction

  // sparse map: about one literal in eight connected
  function automatic logic [FUSES-1:0] fuse_from_seed(input logic [31:0] seed);
    logic [FUSES-1:0] f = '0;
    logic [31:0] s = seed | 32'h1;
    for (int b = 0; b < FUSES; b++) begin
      s = xs(s);
      f[b] = (s[2:0] == 3'd0);
    end
    return f;
  endfunction

  function automatic logic model(input logic [N_IN-1:0] a,
                                 input logic [FUSES-1:0] f,
                                 input logic p);
    logic acc = 1'b0;
    for (int t = 0; t < N_TERMS; t++) begin
      logic used = 1'b0;
      logic prod = 1'b1;
      for (int k = 0; k < N_IN; k++) begin
        if (f[t*LITS + 2*k])   begin used = 1'b1; prod = prod & a[k];  end
        if (f[t*LITS + 2*k+1]) begin used = 1'b1; prod = prod & !a[k]; end
      end
      acc = acc | (used & prod);
    end
    return acc ^ p;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: out_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: out_o=%b expected completion", out);
    finish_run();
  end

  initial begin
    logic [31:0] s;
    rst_ni = 1'b0; arr = '0; fuse = '0; pol = 1'b0; mode = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 reset state", out, 1'b0);
    rst_ni = 1'b1;

    // table of vectors
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      arr = VT[i].arr; pol = VT[i].pol; mode = VT[i].mode;
      fuse = fuse_from_seed(VT[i].seed);
      if (!mode) begin
        #1 check("R6 table comb", out, model(arr, fuse, pol));
      end else begin
        @(negedge clk);
        check("R7 table reg", out, model(arr, fuse, pol));
      end
    end

    // random fuse maps, both modes and polarities
    s = 32'hC0DE_1234;
    for (int i = 0; i < 48; i++) begin
      @(negedge clk);
      s = xs(s); arr = s[15:0];
      pol = i[0]; mode = i[1];
      s = xs(s); fuse = fuse_from_seed(s);
      if (!mode) begin
        #1 check("R4/R5 random comb", out, model(arr, fuse, pol));
      end else begin
        @(negedge clk);
        check("R4/R5 random reg", out, model(arr, fuse, pol));
      end
    end

    // directed, combinational mode
    @(negedge clk);
    mode = 1'b0; pol = 1'b0; fuse = '0; arr = 16'hFFFF;
    #1 check("R3 empty map", out, 1'b0);
    pol = 1'b1;
    #1 check("R5 empty map inverted", out, 1'b1);
    pol = 1'b0;
    fuse = '0; fuse[0*LITS + 2*5] = 1'b1; arr = 16'h0020;
    #1 check("R2 single true literal", out, 1'b1);
    arr = 16'hFFDF;
    #1 check("R2 single true literal low", out, 1'b0);
    fuse = '0; fuse[0*LITS + 2*5+1] = 1'b1; arr = 16'h0000;
    #1 check("R1 complement literal", out, 1'b1);
    fuse[0*LITS + 2*5] = 1'b1;
    #1 check("R1 both literals", out, 1'b0);
    arr = 16'hFFFF;
    #1 check("R1 both literals high", out, 1'b0);
    fuse = '0; fuse[(N_TERMS-1)*LITS + 0] = 1'b1; arr = 16'h0001;
    #1 check("R4 last term", out, 1'b1);
    fuse[2*LITS + 2*1] = 1'b1; arr = 16'h0002;
    #1 check("R4 other term", out, 1'b1);
    pol = 1'b1;
    #1 check("R5 inverted sum", out, 1'b0);
    pol = 1'b0;

    // registered hold
    @(negedge clk);
    fuse = '0; fuse[0*LITS + 2*3] = 1'b1; arr = 16'h0008; mode = 1'b1;
    @(negedge clk);
    check("R7 capture", out, 1'b1);
    arr = 16'h0000;
    #1 check("R7 hold between edges", out, 1'b1);
    @(negedge clk);
    check("R7 next edge", out, 1'b0);

    // mode switch and input change between the same edges
    mode = 1'b0; arr = 16'h0008;
    @(negedge clk);
    check("R6 comb before switch", out, 1'b1);
    arr = 16'h0000; mode = 1'b1;
    #1 check("R9 switch shows sampled value", out, 1'b1);
    @(negedge clk);
    check("R9 after next edge", out, 1'b0);

    // asynchronous reset while holding a 1
    arr = 16'h0008;
    @(negedge clk);
    check("R7 holding one", out, 1'b1);
    rst_ni = 1'b0;
    #1 check("R8 async clear", out, 1'b0);
    @(negedge clk);
    check("R8 held across edge", out, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R8 release then capture", out, 1'b1);

    finish_run();
  end
endmodule